// File: doc/BRIEF.md
# Nibble-coded stack instruction executor

This block runs already-decoded primary instructions. Each one arrives as a 4-bit function code and a full 32-bit operand. There is no prefix assembly. The block keeps a three-deep register stack (A on top, then B, then C), an instruction pointer and a workspace pointer. Every data access is relative either to the workspace pointer or to the word on top of the stack. Offsets count in 4-byte words, so the block scales them by four to form byte addresses. The data port is word addressed and drops the two low byte-address bits.

An upstream fetch/decode stage presents one instruction at a time with `in_valid` and waits for `in_ready`. Register-only instructions finish at the clock edge that accepts them, so they can issue back to back. Loads hold `in_ready` low for two extra cycles. Stores hold it low for one extra cycle, and a subroutine call holds it low for four. The memory answers a read in the cycle after the edge that samples the request.

The instruction pointer counts in instruction slots and advances by one for every instruction. Relative transfers of control add the operand to that advanced value.

Top module: `nib_stack_core`

## Requirements
- R1: While `rst` is high and at the first edge after it, `iptr`=RESET_IPTR, `wptr`=RESET_WPTR, A=B=C=0, `in_ready`=1 and `mem_req`=0.
- R2: Code 4 pushes the operand: A=operand, B=old A, C=old B. It completes in the accepting cycle and sets `iptr`=`iptr`+1.
- R3: Code 0 sets `iptr`=`iptr`+1+operand (modulo 2^32) and leaves the stack unchanged.
- R4: Code 8 sets A=A+operand modulo 2^32 and leaves B and C unchanged.
- R5: Code 12 sets A to 1 when A equals the operand and to 0 otherwise, leaving B and C unchanged.
- R6: Code 10 with A=0 sets `iptr`=`iptr`+1+operand and leaves the stack unchanged. With A non-zero it pops (A=old B, B=old C) and sets `iptr`=`iptr`+1.
- R7: Code 1 pushes the byte address `wptr`+4*operand. Code 5 replaces A with A+4*operand.
- R8: Code 7 reads the word at byte address `wptr`+4*operand and pushes it. `mem_addr` carries byte-address bits [ADDR_W+1:2] with `mem_we`=0, and `in_ready` returns high two cycles after the request cycle.
- R9: Code 13 writes A to byte address `wptr`+4*operand (`mem_we`=1), then pops.
- R10: Code 3 replaces A with the word at byte address A+4*operand. Code 14 writes B to byte address A+4*operand and then sets A=old C.
- R11: Code 11 sets `wptr`=`wptr`+4*operand and leaves the stack unchanged.
- R12: Code 9 lowers `wptr` by 16 and writes four consecutive words from the new `wptr`: `iptr`+1, A, B, C in that order. It sets `iptr`=`iptr`+1+operand and leaves the stack unchanged.
- R13: Code 15 with operand 0x00 swaps A and B, with operand 0x05 sets A=B+A, and with operand 0x0C sets A=B-A. Both arithmetic forms then set B=old C. Any other operand of code 15, and codes 2 and 6, only advance `iptr` by 1.
- R14: `mem_we` is high only together with `mem_req`, and `in_ready` is low whenever `mem_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Block can accept an instruction this cycle |
| in_func | input | 4 | Function code |
| in_operand | input | WORD_W | Full operand |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | WORD_W | Write data |
| mem_rdata | input | WORD_W | Read data, valid the cycle after the sampling edge |
| iptr | output | WORD_W | Instruction pointer |
| wptr | output | WORD_W | Workspace pointer (byte address) |
| stk_a | output | WORD_W | Stack top A |
| stk_b | output | WORD_W | Stack entry B |
| stk_c | output | WORD_W | Stack entry C |

## Verification
The assertions assume three things about the environment. `in_valid` is never raised during reset. The memory returns read data exactly one cycle after the edge that samples a read. Every address the code produces lies within the ADDR_W-bit word space. The stimulus meets all three: it raises `in_valid` for a single cycle only when `in_ready` is high, it models the memory with exactly that one-cycle read latency, and it keeps the workspace and non-local addresses within a small window that the model's 256-word array decodes without aliasing.

// File: rtl/sx_pkg.sv
package sx_pkg;

  typedef enum logic [3:0] {
    FN_J     = 4'h0,
    FN_LDLP  = 4'h1,
    FN_PFIX  = 4'h2,
    FN_LDNL  = 4'h3,
    FN_LDC   = 4'h4,
    FN_LDNLP = 4'h5,
    FN_NFIX  = 4'h6,
    FN_LDL   = 4'h7,
    FN_ADC   = 4'h8,
    FN_CALL  = 4'h9,
    FN_CJ    = 4'hA,
    FN_AJW   = 4'hB,
    FN_EQC   = 4'hC,
    FN_STL   = 4'hD,
    FN_STNL  = 4'hE,
    FN_OPR   = 4'hF
  } fn_e;

  localparam int OPR_REV = 'h00;
  localparam int OPR_ADD = 'h05;
  localparam int OPR_SUB = 'h0C;

  typedef enum logic [2:0] {
    STK_HOLD,
    STK_PUSH,
    STK_POP,
    STK_SETA,
    STK_SWAP,
    STK_POP_SETA,
    STK_POP2
  } stk_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD,
    S_RDATA,
    S_CALL,
    S_WR
  } state_e;

endpackage

// File: rtl/sx_stack.sv
module sx_stack
  import sx_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  stk_op_e           op,
  input  logic [WORD_W-1:0] val,
  output logic [WORD_W-1:0] a,
  output logic [WORD_W-1:0] b,
  output logic [WORD_W-1:0] c
);

  always_ff @(posedge clk) begin
    if (rst) begin
      a <= '0;
      b <= '0;
      c <= '0;
    end else begin
      case (op)
        STK_PUSH: begin
          a <= val;
          b <= a;
          c <= b;
        end
        STK_POP: begin
          a <= b;
          b <= c;
        end
        STK_SETA: a <= val;
        STK_SWAP: begin
          a <= b;
          b <= a;
        end
        STK_POP_SETA: begin
          a <= val;
          b <= c;
        end
        STK_POP2: a <= c;
        default: ;
      endcase
    end
  end

  p_push_shift_r2: assert property (@(posedge clk) disable iff (rst)
    (op == STK_PUSH) |=> (a == $past(val)) && (b == $past(a)) && (c == $past(b)));

  p_pop_shift_r6: assert property (@(posedge clk) disable iff (rst)
    (op == STK_POP) |=> (a == $past(b)) && (b == $past(c)));

  p_swap_r13: assert property (@(posedge clk) disable iff (rst)
    (op == STK_SWAP) |=> (a == $past(b)) && (b == $past(a)) && $stable(c));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (op == STK_HOLD) |=> $stable(a) && $stable(b) && $stable(c));

endmodule

// File: rtl/sx_addr.sv
module sx_addr #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 16
) (
  input  logic [WORD_W-1:0] iptr,
  input  logic [WORD_W-1:0] wptr,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] operand,
  output logic [WORD_W-1:0] loc_byte,
  output logic [WORD_W-1:0] nl_byte,
  output logic [ADDR_W-1:0] loc_word,
  output logic [ADDR_W-1:0] nl_word,
  output logic [WORD_W-1:0] call_byte,
  output logic [ADDR_W-1:0] call_word,
  output logic [WORD_W-1:0] ip_seq,
  output logic [WORD_W-1:0] ip_jump
);

  localparam int SCALE_SH = 2;
  localparam int FRAME_WORDS = 4;
  localparam logic [WORD_W-1:0] FRAME_BYTES = WORD_W'(FRAME_WORDS << SCALE_SH);

  logic [WORD_W-1:0] off_bytes;

  assign off_bytes = operand << SCALE_SH;
  assign loc_byte  = wptr + off_bytes;
  assign nl_byte   = a + off_bytes;
  assign loc_word  = wptr[ADDR_W+SCALE_SH-1:SCALE_SH] + operand[ADDR_W-1:0];
  assign nl_word   = a[ADDR_W+SCALE_SH-1:SCALE_SH] + operand[ADDR_W-1:0];
  assign call_byte = wptr - FRAME_BYTES;
  assign call_word = wptr[ADDR_W+SCALE_SH-1:SCALE_SH] - ADDR_W'(FRAME_WORDS);
  assign ip_seq    = iptr + WORD_W'(1);
  assign ip_jump   = ip_seq + operand;

endmodule

// File: rtl/sx_alu.sv
module sx_alu #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  logic [WORD_W-1:0] operand,
  output logic [WORD_W-1:0] adc_res,
  output logic [WORD_W-1:0] add_res,
  output logic [WORD_W-1:0] sub_res,
  output logic [WORD_W-1:0] eq_res
);

  assign adc_res = a + operand;
  assign add_res = b + a;
  assign sub_res = b - a;
  assign eq_res  = (a == operand) ? WORD_W'(1) : '0;

endmodule

// File: rtl/nib_stack_core.sv
module nib_stack_core
  import sx_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 16,
  parameter logic [WORD_W-1:0] RESET_IPTR = 'h100,
  parameter logic [WORD_W-1:0] RESET_WPTR = 'h1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_func,
  input  logic [WORD_W-1:0] in_operand,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] iptr,
  output logic [WORD_W-1:0] wptr,
  output logic [WORD_W-1:0] stk_a,
  output logic [WORD_W-1:0] stk_b,
  output logic [WORD_W-1:0] stk_c
);

  localparam int SCALE_SH = 2;
  localparam int LAST_SLOT = 3;

  state_e            state;
  logic [1:0]        call_idx;
  logic              load_push;
  logic              accept;
  fn_e               fn;
  stk_op_e           stk_op;
  logic [WORD_W-1:0] stk_val;

  logic [WORD_W-1:0] loc_byte, nl_byte, call_byte, ip_seq, ip_jump;
  logic [ADDR_W-1:0] loc_word, nl_word, call_word;
  logic [WORD_W-1:0] adc_res, add_res, sub_res, eq_res;

  assign fn       = fn_e'(in_func);
  assign in_ready = (state == S_IDLE);
  assign accept   = in_valid && in_ready;

  sx_addr #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_addr (
    .iptr      (iptr),
    .wptr      (wptr),
    .a         (stk_a),
    .operand   (in_operand),
    .loc_byte  (loc_byte),
    .nl_byte   (nl_byte),
    .loc_word  (loc_word),
    .nl_word   (nl_word),
    .call_byte (call_byte),
    .call_word (call_word),
    .ip_seq    (ip_seq),
    .ip_jump   (ip_jump)
  );

  sx_alu #(.WORD_W(WORD_W)) u_alu (
    .a       (stk_a),
    .b       (stk_b),
    .operand (in_operand),
    .adc_res (adc_res),
    .add_res (add_res),
    .sub_res (sub_res),
    .eq_res  (eq_res)
  );

  sx_stack #(.WORD_W(WORD_W)) u_stack (
    .clk (clk),
    .rst (rst),
    .op  (stk_op),
    .val (stk_val),
    .a   (stk_a),
    .b   (stk_b),
    .c   (stk_c)
  );

  // Stack control: load completion or single-cycle instruction effects
  always_comb begin
    stk_op  = STK_HOLD;
    stk_val = '0;
    if (state == S_RDATA) begin
      stk_op  = load_push ? STK_PUSH : STK_SETA;
      stk_val = mem_rdata;
    end else if (accept) begin
      case (fn)
        FN_LDLP: begin
          stk_op  = STK_PUSH;
          stk_val = loc_byte;
        end
        FN_LDC: begin
          stk_op  = STK_PUSH;
          stk_val = in_operand;
        end
        FN_LDNLP: begin
          stk_op  = STK_SETA;
          stk_val = nl_byte;
        end
        FN_ADC: begin
          stk_op  = STK_SETA;
          stk_val = adc_res;
        end
        FN_EQC: begin
          stk_op  = STK_SETA;
          stk_val = eq_res;
        end
        FN_CJ:   if (stk_a != '0) stk_op = STK_POP;
        FN_STL:  stk_op = STK_POP;
        FN_STNL: stk_op = STK_POP2;
        FN_OPR: begin
          if (in_operand == WORD_W'(OPR_REV)) begin
            stk_op = STK_SWAP;
          end else if (in_operand == WORD_W'(OPR_ADD)) begin
            stk_op  = STK_POP_SETA;
            stk_val = add_res;
          end else if (in_operand == WORD_W'(OPR_SUB)) begin
            stk_op  = STK_POP_SETA;
            stk_val = sub_res;
          end
        end
        default: ;
      endcase
    end
  end

  // Sequencer, pointers and registered memory port
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      iptr      <= RESET_IPTR;
      wptr      <= RESET_WPTR;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      call_idx  <= '0;
      load_push <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          mem_req <= 1'b0;
          mem_we  <= 1'b0;
          if (accept) begin
            iptr <= ip_seq;
            case (fn)
              FN_J: iptr <= ip_jump;
              FN_CJ: if (stk_a == '0) iptr <= ip_jump;
              FN_AJW: wptr <= loc_byte;
              FN_LDL: begin
                mem_req   <= 1'b1;
                mem_addr  <= loc_word;
                load_push <= 1'b1;
                state     <= S_RD;
              end
              FN_LDNL: begin
                mem_req   <= 1'b1;
                mem_addr  <= nl_word;
                load_push <= 1'b0;
                state     <= S_RD;
              end
              FN_STL: begin
                mem_req   <= 1'b1;
                mem_we    <= 1'b1;
                mem_addr  <= loc_word;
                mem_wdata <= stk_a;
                state     <= S_WR;
              end
              FN_STNL: begin
                mem_req   <= 1'b1;
                mem_we    <= 1'b1;
                mem_addr  <= nl_word;
                mem_wdata <= stk_b;
                state     <= S_WR;
              end
              FN_CALL: begin
                iptr      <= ip_jump;
                wptr      <= call_byte;
                mem_req   <= 1'b1;
                mem_we    <= 1'b1;
                mem_addr  <= call_word;
                mem_wdata <= ip_seq;
                call_idx  <= 2'd1;
                state     <= S_CALL;
              end
              default: ;
            endcase
          end
        end
        S_RD: begin
          mem_req <= 1'b0;
          state   <= S_RDATA;
        end
        S_RDATA: state <= S_IDLE;
        S_CALL: begin
          mem_addr <= mem_addr + ADDR_W'(1);
          case (call_idx)
            2'd1:    mem_wdata <= stk_a;
            2'd2:    mem_wdata <= stk_b;
            default: mem_wdata <= stk_c;
          endcase
          if (call_idx == 2'(LAST_SLOT)) state <= S_WR;
          else call_idx <= call_idx + 2'd1;
        end
        S_WR: begin
          mem_req <= 1'b0;
          mem_we  <= 1'b0;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_we_with_req_r14: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_req);

  p_ready_excl_r14: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !in_ready);

  p_ldc_push_r2: assert property (@(posedge clk) disable iff (rst)
    (accept && fn == FN_LDC) |=> (stk_a == $past(in_operand)) && (stk_b == $past(stk_a)));

  p_jump_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && fn == FN_J) |=> (iptr == $past(iptr) + WORD_W'(1) + $past(in_operand)));

  p_ajw_r11: assert property (@(posedge clk) disable iff (rst)
    (accept && fn == FN_AJW) |=> (wptr == $past(wptr) + ($past(in_operand) << SCALE_SH)));

  p_call_frame_r12: assert property (@(posedge clk) disable iff (rst)
    (accept && fn == FN_CALL) |=> (wptr == $past(wptr) - WORD_W'(16)) && mem_we && !in_ready);

  p_load_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (accept && (fn == FN_LDL || fn == FN_LDNL)) |=> mem_req && !mem_we ##1 !in_ready ##1 in_ready);

endmodule

// File: tb/nib_stack_core_bench.sv
module nib_stack_core_bench;

  localparam int WORD_W = 32;
  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [3:0]        in_func = '0;
  logic [WORD_W-1:0] in_operand = '0;
  logic              mem_req, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [WORD_W-1:0] mem_wdata;
  logic [WORD_W-1:0] mem_rdata = '0;
  logic [WORD_W-1:0] iptr, wptr, stk_a, stk_b, stk_c;

  logic [WORD_W-1:0] mem [256];

  int checks = 0;
  int errors = 0;

  logic              obs_req, obs_we, obs_ready;
  logic [ADDR_W-1:0] obs_addr;

  always #10 clk = ~clk;

  nib_stack_core u_nib_stack_core (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_func(in_func), .in_operand(in_operand), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .iptr(iptr), .wptr(wptr),
    .stk_a(stk_a), .stk_b(stk_b), .stk_c(stk_c)
  );

  // Memory model: one-cycle read latency, low 8 word-address bits decoded
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[7:0]];
    end
  end

  typedef struct packed {
    logic [3:0]  f;
    logic [31:0] op;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] ip;
    logic [31:0] w;
  } vec_t;

  localparam int NVEC = 20;
  localparam vec_t VECS [NVEC] = '{
    '{4'h4, 32'd5,        32'd5,        32'd0, 32'h101, 32'h1000}, // R2 ldc
    '{4'h4, 32'd7,        32'd7,        32'd5, 32'h102, 32'h1000}, // R2 ldc
    '{4'hF, 32'h05,       32'd12,       32'd0, 32'h103, 32'h1000}, // R13 add
    '{4'h4, 32'd3,        32'd3,        32'd12,32'h104, 32'h1000}, // R2
    '{4'hF, 32'h0C,       32'd9,        32'd0, 32'h105, 32'h1000}, // R13 sub
    '{4'h4, 32'd2,        32'd2,        32'd9, 32'h106, 32'h1000}, // R2
    '{4'hF, 32'h00,       32'd9,        32'd2, 32'h107, 32'h1000}, // R13 rev
    '{4'h8, 32'hFFFFFFF6, 32'hFFFFFFFF, 32'd2, 32'h108, 32'h1000}, // R4 adc wrap
    '{4'hC, 32'hFFFFFFFF, 32'd1,        32'd2, 32'h109, 32'h1000}, // R5 equal
    '{4'hC, 32'd0,        32'd0,        32'd2, 32'h10A, 32'h1000}, // R5 differ
    '{4'hA, 32'h10,       32'd0,        32'd2, 32'h11B, 32'h1000}, // R6 taken
    '{4'h4, 32'd4,        32'd4,        32'd0, 32'h11C, 32'h1000}, // R2
    '{4'hA, 32'h20,       32'd0,        32'd2, 32'h11D, 32'h1000}, // R6 not taken
    '{4'h0, 32'hFFFFFFFB, 32'd0,        32'd2, 32'h119, 32'h1000}, // R3 back jump
    '{4'h1, 32'd3,        32'h100C,     32'd0, 32'h11A, 32'h1000}, // R7 ldlp
    '{4'h5, 32'hFFFFFFFF, 32'h1008,     32'd0, 32'h11B, 32'h1000}, // R7 ldnlp
    '{4'hF, 32'h09,       32'h1008,     32'd0, 32'h11C, 32'h1000}, // R13 other opr
    '{4'h2, 32'h0F,       32'h1008,     32'd0, 32'h11D, 32'h1000}, // R13 prefix
    '{4'hB, 32'd2,        32'h1008,     32'd0, 32'h11E, 32'h1008}, // R11 ajw
    '{4'hB, 32'hFFFFFFFE, 32'h1008,     32'd0, 32'h11F, 32'h1000}  // R11 ajw back
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [3:0] f, input logic [31:0] op);
    @(negedge clk);
    in_valid   = 1'b1;
    in_func    = f;
    in_operand = op;
    @(posedge clk);
    @(negedge clk);
    in_valid  = 1'b0;
    obs_req   = mem_req;
    obs_we    = mem_we;
    obs_addr  = mem_addr;
    obs_ready = in_ready;
    while (!in_ready) @(negedge clk);
  endtask

  task automatic check_reset(input string tag);
    check({tag, " iptr"}, iptr, 32'h100);
    check({tag, " wptr"}, wptr, 32'h1000);
    check({tag, " A"}, stk_a, 32'd0);
    check({tag, " B"}, stk_b, 32'd0);
    check({tag, " C"}, stk_c, 32'd0);
    check({tag, " ready"}, {31'd0, in_ready}, 32'd1);
    check({tag, " req"}, {31'd0, mem_req}, 32'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hA000_0000 | i;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset("R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    check_reset("R1 after release");

    for (int i = 0; i < NVEC; i++) begin
      issue(VECS[i].f, VECS[i].op);
      check($sformatf("vec%0d A", i), stk_a, VECS[i].a);
      check($sformatf("vec%0d B", i), stk_b, VECS[i].b);
      check($sformatf("vec%0d iptr", i), iptr, VECS[i].ip);
      check($sformatf("vec%0d wptr", i), wptr, VECS[i].w);
    end

    // R8 ldl: word 0x402, pushes 0xA0000002
    issue(4'h7, 32'd2);
    check("R8 req", {31'd0, obs_req}, 32'd1);
    check("R8 we", {31'd0, obs_we}, 32'd0);
    check("R8 addr", {16'd0, obs_addr}, 32'h402);
    check("R14 ready low during load", {31'd0, obs_ready}, 32'd0);
    check("R8 A", stk_a, 32'hA000_0002);
    check("R8 B", stk_b, 32'h1008);
    check("R8 C", stk_c, 32'd0);

    // R9 stl: A to word 0x405, pop
    issue(4'hD, 32'd5);
    check("R9 we", {31'd0, obs_we}, 32'd1);
    check("R9 addr", {16'd0, obs_addr}, 32'h405);
    check("R9 mem", mem[5], 32'hA000_0002);
    check("R9 A", stk_a, 32'h1008);
    check("R9 B", stk_b, 32'd0);

    // R10 ldnl: A=0x1008 +4 -> word 0x403
    issue(4'h3, 32'd1);
    check("R10 ldnl addr", {16'd0, obs_addr}, 32'h403);
    check("R10 ldnl A", stk_a, 32'hA000_0003);
    check("R10 ldnl B", stk_b, 32'd0);

    // R10 stnl: B to A+24 -> word 0x406, then A=C
    issue(4'h4, 32'h55AA);
    issue(4'h4, 32'h1000);
    issue(4'hE, 32'd6);
    check("R10 stnl addr", {16'd0, obs_addr}, 32'h406);
    check("R10 stnl mem", mem[6], 32'h55AA);
    check("R10 stnl A", stk_a, 32'hA000_0003);

    // R12 call: iptr 0x128 before
    issue(4'h4, 32'h11);
    issue(4'h4, 32'h22);
    issue(4'h4, 32'h33);
    check("R2 iptr before call", iptr, 32'h128);
    issue(4'h9, 32'h40);
    check("R12 first addr", {16'd0, obs_addr}, 32'h3FC);
    check("R14 ready low during call", {31'd0, obs_ready}, 32'd0);
    check("R12 wptr", wptr, 32'hFF0);
    check("R12 iptr", iptr, 32'h169);
    check("R12 ret", mem[8'hFC], 32'h129);
    check("R12 saved A", mem[8'hFD], 32'h33);
    check("R12 saved B", mem[8'hFE], 32'h22);
    check("R12 saved C", mem[8'hFF], 32'h11);
    check("R12 A kept", stk_a, 32'h33);
    check("R12 B kept", stk_b, 32'h22);
    check("R12 C kept", stk_c, 32'h11);

    // R1 reset again mid-state
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check_reset("R1 re-reset");
    rst = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule